// File: doc/BRIEF.md
# Interrupt Priority and Delegation Selector

This combinational block decides, in the same cycle its inputs change, whether a hart should take an interrupt now, and which one. It receives the vector of interrupts that are both pending and individually enabled, the current privilege level, the global machine and supervisor interrupt-enable bits, the delegation mask and the debug cause field. It produces a take strobe and a cause word for the trap-entry logic that sits around it.

Undelegated interrupts form the machine-level candidate set and delegated ones form the supervisor-level set. An enabled machine-level candidate always hides every supervisor-level one. Among the survivors, one interrupt is picked by group: custom lines above index 11 come first, then the external pair (11, 9), then the software pair (3, 1), then the timer pair (7, 5), and last any other bit. Inside the winning group the lowest index wins. The cause word has its top bit set and carries the chosen index in its low bits.

Top module: `irq_priority_select`

## Requirements
- R1: Undelegated pending bits are eligible when privilege (2-bit, 0 user, 1 supervisor, 3 machine) is below 3, or is 3 with the machine enable bit high; otherwise none of them is eligible.
- R2: Delegated pending bits are looked at only when the eligible machine-level set is empty; if any machine-level bit is eligible, the chosen index is never a delegated one.
- R3: Delegated pending bits are eligible when privilege is 0, or is 1 with the supervisor enable bit high; at privilege 3 they are never taken.
- R4: While the debug cause input is nonzero, no interrupt is taken.
- R5: If any eligible bit sits at an index of 12 or more, the choice is made among those bits only.
- R6: Otherwise, if bit 11 or bit 9 is eligible, the choice is made among those two.
- R7: Otherwise, if bit 3 or bit 1 is eligible, the choice is made among those two; failing that, among bits 7 and 5.
- R8: If no group above holds an eligible bit, the choice is made among the remaining eligible bits.
- R9: Within the group in force, the lowest eligible index is chosen.
- R10: When an interrupt is taken, the take output is 1, cause bit XLEN-1 is 1 and cause bits below it hold the chosen index, zero-extended.
- R11: When nothing is eligible, take is 0 and the cause word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_en_i | input | XLEN | Interrupts that are pending and individually enabled |
| deleg_i | input | XLEN | Delegation mask: 1 routes the bit to supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| dbg_cause_i | input | 3 | Debug cause field; nonzero means the hart is in debug mode |
| take_o | output | 1 | An interrupt is to be taken now |
| cause_o | output | XLEN | Interrupt flag in the top bit, chosen index in the low bits |

## Verification
The assertions take for granted that the privilege input never carries the reserved value 2 and that the inputs are settled when the combinational checks evaluate. The bench draws privilege only from 0, 1 and 3 and changes all inputs together in one step after a rising edge. Random vectors alternate between full-width values and values restricted to the low twelve bits, so the external, software, timer and leftover groups all win often, and delegation masks are drawn so that both levels compete on the same vector.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    GRP_NONE   = 3'd0,
    GRP_CUSTOM = 3'd1,
    GRP_EXT    = 3'd2,
    GRP_SOFT   = 3'd3,
    GRP_TIMER  = 3'd4,
    GRP_OTHER  = 3'd5
  } grp_e;

  localparam int IDX_M_EXT   = 11;
  localparam int IDX_S_EXT   = 9;
  localparam int IDX_M_SOFT  = 3;
  localparam int IDX_S_SOFT  = 1;
  localparam int IDX_M_TIMER = 7;
  localparam int IDX_S_TIMER = 5;

  // Level enable: strictly below the level, or at it with its global enable.
  function automatic logic level_open(input logic [1:0] priv,
                                      input logic [1:0] level,
                                      input logic gie);
    return (priv < level) || ((priv == level) && gie);
  endfunction

  // Two-bit pair mask for a group.
  function automatic logic [63:0] pair_mask(input int a, input int b);
    return (64'd1 << a) | (64'd1 << b);
  endfunction

  // All indices strictly above the machine external line.
  function automatic logic [63:0] custom_mask();
    return ~((64'd1 << (IDX_M_EXT + 1)) - 64'd1);
  endfunction

endpackage

// File: rtl/irq_cand_filter.sv
module irq_cand_filter
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pend_en_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic [2:0]      dbg_cause_i,
  output logic [XLEN-1:0] cand_o,
  output logic            m_live_o,
  output logic            in_debug_o
);

  logic            m_open;
  logic            s_open;
  logic [XLEN-1:0] m_set;
  logic [XLEN-1:0] s_set;
  logic [XLEN-1:0] chosen_set;

  always_comb begin
    m_open = level_open(priv_i, PRIV_MACH, m_gie_i);
    s_open = level_open(priv_i, PRIV_SUPER, s_gie_i);
    m_set  = m_open ? (pend_en_i & ~deleg_i) : '0;
    s_set  = s_open ? (pend_en_i & deleg_i) : '0;
  end

  assign m_live_o   = |m_set;
  assign in_debug_o = |dbg_cause_i;

  always_comb begin
    if (m_live_o) chosen_set = m_set;
    else          chosen_set = s_set;
  end

  assign cand_o = in_debug_o ? '0 : chosen_set;

endmodule

// File: rtl/irq_group_mask.sv
module irq_group_mask
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cand_i,
  output logic [XLEN-1:0] grp_bits_o,
  output grp_e            grp_o
);

  localparam logic [XLEN-1:0] CUSTOM_M = XLEN'(custom_mask());
  localparam logic [XLEN-1:0] EXT_M    = XLEN'(pair_mask(IDX_M_EXT, IDX_S_EXT));
  localparam logic [XLEN-1:0] SOFT_M   = XLEN'(pair_mask(IDX_M_SOFT, IDX_S_SOFT));
  localparam logic [XLEN-1:0] TIMER_M  = XLEN'(pair_mask(IDX_M_TIMER, IDX_S_TIMER));

  logic [XLEN-1:0] in_custom;
  logic [XLEN-1:0] in_ext;
  logic [XLEN-1:0] in_soft;
  logic [XLEN-1:0] in_timer;

  assign in_custom = cand_i & CUSTOM_M;
  assign in_ext    = cand_i & EXT_M;
  assign in_soft   = cand_i & SOFT_M;
  assign in_timer  = cand_i & TIMER_M;

  always_comb begin
    if (|in_custom) begin
      grp_bits_o = in_custom;
      grp_o      = GRP_CUSTOM;
    end else if (|in_ext) begin
      grp_bits_o = in_ext;
      grp_o      = GRP_EXT;
    end else if (|in_soft) begin
      grp_bits_o = in_soft;
      grp_o      = GRP_SOFT;
    end else if (|in_timer) begin
      grp_bits_o = in_timer;
      grp_o      = GRP_TIMER;
    end else if (|cand_i) begin
      grp_bits_o = cand_i;
      grp_o      = GRP_OTHER;
    end else begin
      grp_bits_o = '0;
      grp_o      = GRP_NONE;
    end
  end

endmodule

// File: rtl/irq_lowest_index.sv
module irq_lowest_index #(
  parameter int XLEN = 64,
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] bits_i,
  output logic            found_o,
  output logic [IDXW-1:0] idx_o
);

  // Scan from the top down so the last hit is the lowest set bit.
  always_comb begin
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (bits_i[i]) idx_o = IDXW'(i);
    end
  end

  assign found_o = |bits_i;

endmodule

// File: rtl/irq_priority_select.sv
module irq_priority_select
  import irq_sel_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pend_en_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_gie_i,
  input  logic            s_gie_i,
  input  logic [2:0]      dbg_cause_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);

  localparam int IDXW = $clog2(XLEN);

  logic [XLEN-1:0] cand;
  logic            m_live;
  logic            in_debug;
  logic [XLEN-1:0] grp_bits;
  grp_e            grp;
  logic            found;
  logic [IDXW-1:0] win_idx;

  irq_cand_filter #(.XLEN(XLEN)) u_filter (
    .pend_en_i   (pend_en_i),
    .deleg_i     (deleg_i),
    .priv_i      (priv_i),
    .m_gie_i     (m_gie_i),
    .s_gie_i     (s_gie_i),
    .dbg_cause_i (dbg_cause_i),
    .cand_o      (cand),
    .m_live_o    (m_live),
    .in_debug_o  (in_debug)
  );

  irq_group_mask #(.XLEN(XLEN)) u_group (
    .cand_i     (cand),
    .grp_bits_o (grp_bits),
    .grp_o      (grp)
  );

  irq_lowest_index #(.XLEN(XLEN)) u_index (
    .bits_i  (grp_bits),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_comb begin
    take_o  = found;
    cause_o = '0;
    if (found) begin
      cause_o[IDXW-1:0] = win_idx;
      cause_o[XLEN-1]   = 1'b1;
    end
  end

  // Checks across the filter, group and index stages.
  always_comb begin
    if (priv_i != 2'd2) begin
      p_debug_blocks_r4: assert (!(in_debug && take_o));
      p_idle_zero_r11: assert (take_o || (cause_o == '0));
      p_flag_set_r10: assert (!take_o || cause_o[XLEN-1]);
      p_pick_pending_r9: assert (!take_o || pend_en_i[win_idx]);
      p_shadow_r2: assert (!(take_o && m_live) || !deleg_i[win_idx]);
      p_custom_first_r5: assert (!(take_o && (grp == GRP_CUSTOM))
                                 || (int'(win_idx) > IDX_M_EXT));
      p_ext_pair_r6: assert (!(take_o && (grp == GRP_EXT))
                             || (int'(win_idx) == IDX_M_EXT)
                             || (int'(win_idx) == IDX_S_EXT));
      p_machine_closed_r1: assert (!((priv_i == 2'd3) && !m_gie_i && take_o)
                                   || deleg_i[win_idx]);
      p_super_closed_r3: assert (!((priv_i == 2'd3) && take_o)
                                 || !deleg_i[win_idx]);
    end
  end

endmodule

// File: tb/sim_irq_priority_select.sv
module sim_irq_priority_select;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic [XLEN-1:0] pend_en;
  logic [XLEN-1:0] deleg;
  logic [1:0]      priv;
  logic            m_gie;
  logic            s_gie;
  logic [2:0]      dbg;
  logic            take;
  logic [XLEN-1:0] cause;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  irq_priority_select #(.XLEN(XLEN)) u0 (
    .pend_en_i   (pend_en),
    .deleg_i     (deleg),
    .priv_i      (priv),
    .m_gie_i     (m_gie),
    .s_gie_i     (s_gie),
    .dbg_cause_i (dbg),
    .take_o      (take),
    .cause_o     (cause)
  );

  // Behavioural reference: returns chosen index or -1.
  function automatic int model_pick();
    logic [XLEN-1:0] live;
    logic [XLEN-1:0] pool;
    int pick;
    bit m_ok;
    bit s_ok;
    m_ok = (priv == 2'd0) || (priv == 2'd1) || (priv == 2'd3 && m_gie);
    s_ok = (priv == 2'd0) || (priv == 2'd1 && s_gie);
    live = m_ok ? (pend_en & ~deleg) : '0;
    if (live == 0) live = s_ok ? (pend_en & deleg) : '0;
    if (dbg != 0 || live == 0) return -1;
    pool = 0;
    for (int i = 12; i < XLEN; i++) pool[i] = live[i];
    if (pool == 0) begin pool[11] = live[11]; pool[9] = live[9]; end
    if (pool == 0) begin pool[3] = live[3]; pool[1] = live[1]; end
    if (pool == 0) begin pool[7] = live[7]; pool[5] = live[5]; end
    if (pool == 0) pool = live;
    pick = -1;
    for (int i = 0; i < XLEN && pick < 0; i++) if (pool[i]) pick = i;
    return pick;
  endfunction

  task automatic apply(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
                       input logic [1:0] pv, input logic mg, input logic sg,
                       input logic [2:0] dc, input string tag);
    int k;
    logic            e_take;
    logic [XLEN-1:0] e_cause;
    @(posedge clk);
    pend_en = p; deleg = d; priv = pv; m_gie = mg; s_gie = sg; dbg = dc;
    @(negedge clk);
    k = model_pick();
    e_take  = (k >= 0);
    e_cause = e_take ? ((64'd1 << (XLEN - 1)) | XLEN'(k)) : '0;
    checks++;
    if (take !== e_take || cause !== e_cause) begin
      fails++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
               tag, take, cause, e_take, e_cause);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  function automatic logic [XLEN-1:0] b(input int i);
    return 64'd1 << i;
  endfunction

  initial begin
    pend_en = '0; deleg = '0; priv = 2'd3; m_gie = 0; s_gie = 0; dbg = 0;
    // R11: idle inputs give no take and zero cause
    apply('0, '0, 2'd3, 1, 1, 0, "R11 idle");
    // R1: machine level gated by its enable at privilege 3
    apply(b(7), '0, 2'd3, 0, 0, 0, "R1 machine closed");
    apply(b(7), '0, 2'd3, 1, 0, 0, "R1 machine open");
    apply(b(3), '0, 2'd1, 0, 0, 0, "R1 below machine");
    // R3: supervisor level rules
    apply(b(5), b(5), 2'd1, 1, 0, 0, "R3 super closed");
    apply(b(5), b(5), 2'd1, 0, 1, 0, "R3 super open");
    apply(b(5), b(5), 2'd3, 1, 1, 0, "R3 at machine");
    apply(b(5), b(5), 2'd0, 0, 0, 0, "R3 from user");
    // R2: machine candidate shadows a higher-group supervisor one
    apply(b(9) | b(7), b(9), 2'd1, 0, 1, 0, "R2 shadow");
    apply(b(9) | b(7), b(9), 2'd3, 0, 1, 0, "R2 none open");
    // R4: debug blocks everything
    apply(b(11), '0, 2'd0, 1, 1, 3'd2, "R4 debug");
    // R5..R9 group ordering and lowest index
    apply(b(13) | b(11), '0, 2'd0, 0, 0, 0, "R5 custom first");
    apply(b(40) | b(20), '0, 2'd0, 0, 0, 0, "R9 lowest custom");
    apply(b(9) | b(3), '0, 2'd0, 0, 0, 0, "R6 external over software");
    apply(b(11) | b(9), '0, 2'd0, 0, 0, 0, "R9 lowest external");
    apply(b(1) | b(7), '0, 2'd0, 0, 0, 0, "R7 software over timer");
    apply(b(0) | b(5), '0, 2'd0, 0, 0, 0, "R7 timer over other");
    apply(b(2) | b(0), '0, 2'd0, 0, 0, 0, "R8 leftover bits");
    apply(b(63), '0, 2'd0, 0, 0, 0, "R10 top index");
    // Random sweep
    for (int n = 0; n < 600; n++) begin
      logic [XLEN-1:0] rp;
      logic [XLEN-1:0] rd;
      logic [1:0] rv;
      logic [2:0] rc;
      rp = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      if (n % 2 == 0) rp = rp & 64'hFFF;
      if (n % 3 == 0) rp = rp & {$urandom, $urandom};
      case ($urandom_range(0, 2))
        0: rv = 2'd0;
        1: rv = 2'd1;
        default: rv = 2'd3;
      endcase
      rc = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      apply(rp, rd, rv, 1'($urandom), 1'($urandom), rc, "R10 random");
    end
    finish_run();
  end

endmodule